// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches eight general-purpose input pins and turns their activity into interrupt requests. Each pin first passes through a two-stage synchronizer. A set of per-pin control bits then chooses what counts as an event on that pin: an edge or a level, which polarity, and whether both edges count. Events set per-pin raw status bits. A mask selects which of them reach the single combined interrupt output.

Software reaches the controls and status through a single-cycle register port. It reads with zero wait states, because read data is a function of the address. Writes take effect at the next clock edge. Edge events latch until software writes a one to the matching bit of the clear register. Level events have no memory and follow the pin.

Top module: `gpio_irq_detect`

## Requirements
- R1: A pin change is seen only after a two-flop synchronizer. If a pin changes before rising edge k, a latched edge status is visible after edge k+2. A matching level status is visible after edge k+1.
- R2: The sense register at byte offset 0x404 holds bit i for pin i. A 1 selects level detection and a 0 selects edge detection. It resets to 0.
- R3: The polarity register at 0x40C selects rising edge or high level when bit i is 1, and falling edge or low level when it is 0. With both-edges off, only that one edge sets the status. It resets to 0.
- R4: The both-edges register at 0x408 works on a pin in edge mode. When bit i is 1, rising and falling edges both set the status, whatever the polarity bit says.
- R5: In level mode the both-edges bit has no influence on the status.
- R6: Bits 31:8 of every register read as 0, and writes to them are ignored. All control registers reset to 0.
- R7: An edge status bit stays set until a write to 0x41C carries a 1 in its bit. Writing a 0 in a bit leaves that bit alone.
- R8: A level status bit reads 1 exactly while the synchronized pin matches the polarity bit. Writes to the clear register do not affect it.
- R9: If a new edge and a clear of the same pin fall on the same clock edge, the status bit stays set.
- R10: The mask is at 0x410. Raw status at 0x414 and masked status at 0x418 (raw AND mask) are read-only, and writes to them change nothing.
- R11: irq_o is the OR of the masked status bits and changes in the same cycle as them.
- R12: The clear register and unmapped offsets read as 0. The two low address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous pin inputs |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Read data and irq_o are combinational on the current address and state. The bench therefore samples both on the falling clock edge and drives inputs just after the rising edge. Its model keeps the last three pin samples in a queue. An edge found between the two older samples sets the latched status at the edge where it is found, which is two edges after the pin changes. A level status follows the middle sample, one edge after the pin changes. The same-cycle clear case is timed so that the clear write lands on exactly the edge where the edge is found.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_AW = 12;
  localparam logic [REG_AW-1:0] OFF_SENSE = 12'h404;
  localparam logic [REG_AW-1:0] OFF_BOTH  = 12'h408;
  localparam logic [REG_AW-1:0] OFF_POL   = 12'h40C;
  localparam logic [REG_AW-1:0] OFF_MASK  = 12'h410;
  localparam logic [REG_AW-1:0] OFF_RAW   = 12'h414;
  localparam logic [REG_AW-1:0] OFF_MSK_S = 12'h418;
  localparam logic [REG_AW-1:0] OFF_CLR   = 12'h41C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SENSE, SEL_BOTH, SEL_POL, SEL_MASK, SEL_RAW, SEL_MSK_S, SEL_CLR
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] sync_o,
  output logic [NUM_PINS-1:0] prev_o
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign sync_o[g] = sync_q;
    assign prev_o[g] = prev_q;
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0] raw_i,
  input  logic [NUM_PINS-1:0] msk_i,
  output logic [NUM_PINS-1:0] sense_o,
  output logic [NUM_PINS-1:0] both_o,
  output logic [NUM_PINS-1:0] pol_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] clr_o,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_PINS;

  logic [ADDR_W-1:0]   word_addr;
  reg_sel_e            sel;
  logic [NUM_PINS-1:0] sense_q, both_q, pol_q, mask_q, rd_bits;
  logic [NUM_PINS-1:0] wbits;

  assign word_addr = {addr_i[ADDR_W-1:2], 2'b00};
  assign wbits     = wdata_i[NUM_PINS-1:0];

  always_comb begin
    case (word_addr)
      ADDR_W'(OFF_SENSE): sel = SEL_SENSE;
      ADDR_W'(OFF_BOTH):  sel = SEL_BOTH;
      ADDR_W'(OFF_POL):   sel = SEL_POL;
      ADDR_W'(OFF_MASK):  sel = SEL_MASK;
      ADDR_W'(OFF_RAW):   sel = SEL_RAW;
      ADDR_W'(OFF_MSK_S): sel = SEL_MSK_S;
      ADDR_W'(OFF_CLR):   sel = SEL_CLR;
      default:            sel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
    end else if (we_i) begin
      if (sel == SEL_SENSE) sense_q <= wbits;
      if (sel == SEL_BOTH)  both_q  <= wbits;
      if (sel == SEL_POL)   pol_q   <= wbits;
      if (sel == SEL_MASK)  mask_q  <= wbits;
    end
  end

  assign clr_o = (we_i && sel == SEL_CLR) ? wbits : '0;

  always_comb begin
    case (sel)
      SEL_SENSE: rd_bits = sense_q;
      SEL_BOTH:  rd_bits = both_q;
      SEL_POL:   rd_bits = pol_q;
      SEL_MASK:  rd_bits = mask_q;
      SEL_RAW:   rd_bits = raw_i;
      SEL_MSK_S: rd_bits = msk_i;
      default:   rd_bits = '0;
    endcase
  end

  assign rdata_o = {{PAD_W{1'b0}}, rd_bits};
  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign pol_o   = pol_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] sync_i,
  input  logic [NUM_PINS-1:0] prev_i,
  input  logic [NUM_PINS-1:0] sense_i,
  input  logic [NUM_PINS-1:0] both_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] raw_o,
  output logic [NUM_PINS-1:0] msk_o,
  output logic                irq_o
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit, latch_q;
    assign rise     = sync_i[g] & ~prev_i[g];
    assign fall     = ~sync_i[g] & prev_i[g];
    // both-edges overrides polarity; only meaningful in edge mode
    assign edge_hit = both_i[g] ? (rise | fall) : (pol_i[g] ? rise : fall);
    assign lvl_hit  = (sync_i[g] == pol_i[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         latch_q <= 1'b0;
      else if (sense_i[g]) latch_q <= 1'b0;
      else                 latch_q <= edge_hit | (latch_q & ~clr_i[g]);
    end

    assign raw_o[g] = sense_i[g] ? lvl_hit : latch_q;
  end

  assign msk_o = raw_o & mask_i;
  assign irq_o = |msk_o;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] sync_w, prev_w, sense_w, both_w, pol_w, mask_w, clr_w, raw_w, msk_w;

  gpio_irq_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .pin_i (pin_i),
    .sync_o(sync_w), .prev_o(prev_w)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i  (clk_i),  .rst_ni (rst_ni), .we_i  (we_i),
    .addr_i (addr_i), .wdata_i(wdata_i),
    .raw_i  (raw_w),  .msk_i  (msk_w),
    .sense_o(sense_w), .both_o(both_w), .pol_o(pol_w), .mask_o(mask_w),
    .clr_o  (clr_w),  .rdata_o(rdata_o)
  );

  gpio_irq_core #(.NUM_PINS(NUM_PINS)) u_core (
    .clk_i  (clk_i),   .rst_ni(rst_ni),
    .sync_i (sync_w),  .prev_i(prev_w),
    .sense_i(sense_w), .both_i(both_w), .pol_i(pol_w), .mask_i(mask_w),
    .clr_i  (clr_w),
    .raw_o  (raw_w),   .msk_o (msk_w),  .irq_o(irq_o)
  );
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] sense_i,
  input logic [NUM_PINS-1:0] both_i,
  input logic [NUM_PINS-1:0] sync_i,
  input logic [NUM_PINS-1:0] prev_i,
  input logic [NUM_PINS-1:0] raw_i
);
  logic [ADDR_W-1:0] wa;
  logic              clr_wr;
  assign wa     = {addr_i[ADDR_W-1:2], 2'b00};
  assign clr_wr = we_i && (wa == ADDR_W'(OFF_CLR));

  a_r6_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:NUM_PINS] == '0);

  a_r11_irq_matches_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wa == ADDR_W'(OFF_MSK_S)) |-> (irq_o == |rdata_o[NUM_PINS-1:0]));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    a_r4_both_edges_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!we_i && !sense_i[g] && both_i[g] && (sync_i[g] != prev_i[g])) |=> raw_i[g]);

    a_r7_edge_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!we_i && !sense_i[g] && raw_i[g]) |=> raw_i[g]);

    a_r7_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_wr && wdata_i[g] && !sense_i[g] && (sync_i[g] == prev_i[g])) |=> !raw_i[g]);

    a_r9_edge_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_wr && wdata_i[g] && !sense_i[g] && both_i[g] && (sync_i[g] != prev_i[g])) |=> raw_i[g]);
  end
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i  (clk_i),  .rst_ni (rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .sense_i(sense_w), .both_i(both_w), .sync_i(sync_w), .prev_i(prev_w),
  .raw_i  (raw_w)
);

// File: tb/gpio_irq_detect_test.sv
`timescale 1ns/1ps
module gpio_irq_detect_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  pin_i = '0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R6";
  logic [11:0] view_addr = 12'h414;
  bit    done = 0;

  gpio_irq_detect uut (.*);

  always #5 clk_i = ~clk_i;

  // behavioural reference
  bit [7:0] m_sense, m_both, m_pol, m_mask, m_latch;
  bit [7:0] hist[$] = '{8'h0, 8'h0, 8'h0};

  function automatic bit [7:0] m_raw();
    bit [7:0] r;
    for (int j = 0; j < 8; j++)
      r[j] = m_sense[j] ? (hist[1][j] == m_pol[j]) : m_latch[j];
    return r;
  endfunction

  function automatic bit [31:0] m_read(input bit [11:0] a);
    case ({a[11:2], 2'b00})
      12'h404: return {24'h0, m_sense};
      12'h408: return {24'h0, m_both};
      12'h40C: return {24'h0, m_pol};
      12'h410: return {24'h0, m_mask};
      12'h414: return {24'h0, m_raw()};
      12'h418: return {24'h0, m_raw() & m_mask};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sense = 0; m_both = 0; m_pol = 0; m_mask = 0; m_latch = 0;
      hist = '{8'h0, 8'h0, 8'h0};
    end else begin
      bit [7:0] nl;
      bit [11:0] wa;
      wa = {addr_i[11:2], 2'b00};
      for (int j = 0; j < 8; j++) begin
        bit s, p, hit, clr;
        s = hist[1][j]; p = hist[2][j];
        if (m_both[j]) hit = (s != p);
        else if (m_pol[j]) hit = s & !p;
        else hit = !s & p;
        clr = we_i && wa == 12'h41C && wdata_i[j];
        nl[j] = m_sense[j] ? 1'b0 : (hit | (m_latch[j] & !clr));
      end
      if (we_i) begin
        case (wa)
          12'h404: m_sense = wdata_i[7:0];
          12'h408: m_both  = wdata_i[7:0];
          12'h40C: m_pol   = wdata_i[7:0];
          12'h410: m_mask  = wdata_i[7:0];
          default: ;
        endcase
      end
      m_latch = nl;
      hist.push_front(pin_i);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit [31:0] er;
      bit ei;
      er = m_read(addr_i);
      ei = |(m_raw() & m_mask);
      n_cmp++;
      if (rdata_o !== er) begin
        n_bad++;
        $display("FAIL %s rdata @%h: actual %h expected %h", cur_req, addr_i, rdata_o, er);
      end
      n_cmp++;
      if (irq_o !== ei) begin
        n_bad++;
        $display("FAIL %s irq_o: actual %b expected %b", cur_req, irq_o, ei);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic look(input logic [11:0] a);
    @(posedge clk_i); #2;
    view_addr = a; addr_i = a;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk_i); #2;
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #2;
    we_i = 1'b0; addr_i = view_addr; wdata_i = '0;
  endtask

  task automatic pins(input logic [7:0] v, input int settle);
    @(posedge clk_i); #2;
    pin_i = v;
    idle(settle);
  endtask

  initial begin
    idle(3); #2; rst_ni = 1'b1;
    // R6 R2 R3 R12: reset values, unmapped reads
    cur_req = "R6";
    for (int a = 12'h400; a <= 12'h420; a += 4) look(a[11:0]);
    cur_req = "R12";
    look(12'h41D); look(12'h7FC);
    cur_req = "R6";
    wr(12'h408, 32'hFFFF_FFFF); look(12'h408); look(12'h40A);
    wr(12'h408, 32'h0);
    // R1 R3: falling edge default, then rising
    cur_req = "R1";
    wr(12'h410, 32'hFF);
    look(12'h414);
    pins(8'h0F, 4);
    cur_req = "R3";
    pins(8'h00, 4);
    look(12'h418);
    wr(12'h41C, 32'hFF);
    wr(12'h40C, 32'h0F);
    pins(8'hFF, 4);
    pins(8'h00, 4);
    // R7 partial clears
    cur_req = "R7";
    look(12'h414);
    wr(12'h41C, 32'h03);
    idle(2);
    wr(12'h41C, 32'h00);
    wr(12'h41C, 32'hFFFF_FF0C);
    idle(2);
    // R4 both edges ignores polarity
    cur_req = "R4";
    wr(12'h408, 32'hF0);
    pins(8'hF0, 4);
    wr(12'h41C, 32'hFF);
    pins(8'h00, 4);
    wr(12'h41C, 32'hFF);
    pins(8'h55, 4);
    // R9 edge and clear in the same cycle
    cur_req = "R9";
    wr(12'h41C, 32'hFF);
    pins(8'hA0, 1);
    wr(12'h41C, 32'hFF);
    idle(3);
    // R10 read-only status, mask
    cur_req = "R10";
    wr(12'h410, 32'h30);
    look(12'h418);
    wr(12'h414, 32'h00);
    wr(12'h418, 32'h00);
    look(12'h414);
    // R11 irq follows masked
    cur_req = "R11";
    wr(12'h410, 32'h00);
    idle(2);
    wr(12'h410, 32'h80);
    idle(2);
    // R5 R8 level mode
    cur_req = "R8";
    wr(12'h408, 32'h00);
    wr(12'h40C, 32'hAA);
    wr(12'h404, 32'hFF);
    wr(12'h410, 32'hFF);
    pins(8'hAA, 3);
    pins(8'h0F, 3);
    wr(12'h41C, 32'hFF);
    cur_req = "R5";
    wr(12'h408, 32'hFF);
    pins(8'hF0, 3);
    pins(8'h00, 3);
    cur_req = "R2";
    wr(12'h404, 32'h0F);
    pins(8'hFF, 4);
    look(12'h404);
    look(12'h418);
    idle(2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL all: watchdog, actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule